// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block is the parallel port through which a host processor reaches the registers and FIFOs of a peripheral controller. A mode input picks one of two address schemes. In split mode, a 7-bit address bus carries the address and the 8-bit AD bus carries the low data byte. In multiplexed mode, the AD bus carries both. An address strobe captures the address and the chip select, and the data follows on the same bus. Each accepted read or write becomes a one-cycle enable toward an internal register file. The block keeps three of its own registers: signal polarity, control and status.

Two DMA channels bypass the address decode. While a channel's acknowledge is active, the read and write strobes go straight to that channel's FIFO, whatever the chip select does. The interrupt and DMA request outputs and the DMA acknowledge inputs each have a programmable polarity. In split mode the address-strobe pin becomes a pull-up control output.

Top module: `host_bus_if`

## Requirements
- R1: In split mode (`mode_mux`=0), with `cs_n` low and no DMA acknowledge active, `reg_wr` pulses for exactly one cycle. The pulse comes in the first cycle that `wr_n` is sampled low after being high. In that cycle `reg_addr` equals `addr_in` and `reg_wdata` equals `ad_in`.
- R2: In multiplexed mode (`mode_mux`=1), the address is `ad_in[6:0]` and the chip select is `cs_n`, both as captured at the last clock edge with `ale_in` high. They hold while `ale_in` is low. After an address phase, `reg_addr` shows the captured address.
- R3: With the effective chip select high and no DMA acknowledge active, strobes produce no `reg_wr`, `reg_rd`, `fifo_wr` or `fifo_rd`, and `ad_oe` stays 0.
- R4: A selected read pulses `reg_rd` once, in the first cycle that `rd_n` is sampled low. `ad_oe` is 1 for every cycle that `rd_n` is low. `ad_out` is `reg_rdata` for ordinary addresses.
- R5: While a DMA acknowledge is active, `cs_n` and the address are ignored. A write strobe pulses that channel's bit of `fifo_wr` (bit 0 for channel 0), and `fifo_wdata` = {`dhi_in`,`ad_in`}. A read strobe pulses `fifo_rd`, with `ad_out` = `fifo_rdata[7:0]`. No `reg_wr` or `reg_rd` occurs.
- R6: The polarity register sits at address 0x7C. Bit0 makes `irq_pin` active high. Bits 1 and 2 make `dreq_pin[0]` and `dreq_pin[1]` active high. Bits 3 and 4 make `dack_pin[0]` and `dack_pin[1]` active low.
- R7: After reset, `irq_pin` = ~`irq_int`, `dreq_pin` = ~`dreq_int`, and a `dack_pin` bit at 1 means acknowledge.
- R8: Control register bit3 is the pull-up enable. In split mode, `ale_oe` equals that bit, and `ale_out` is 1 whenever it is driven. In multiplexed mode, `ale_oe` is 0.
- R9: Control register bits 0 and 1 mark DMA channel 0 and channel 1 as 16-bit. `dhi_oe` is 1 only while `rd_n` is low during a DMA read on a 16-bit channel. `dhi_out` is then `fifo_rdata[15:8]`.
- R10: When both acknowledges are active, channel 0 is served. Status bit0 is then set and stays set. Writing a 1 to status bit0 clears it, unless a new conflict occurs in the same cycle.
- R11: The local registers sit at 0x7C (polarity, 5 bits), 0x7D (control, 8 bits) and 0x7E (status). They read back through `ad_out`. Accesses to them produce no `reg_wr` or `reg_rd`.
- R12: While `rst_n` is low, the polarity, control and status registers are cleared, and so are the captured address and the captured chip select (which resets high). Strobe history is reset as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mux | input | 1 | 0: split address bus, 1: address multiplexed on AD |
| addr_in | input | 7 | Address bus in split mode |
| ad_in | input | 8 | AD bus input: low data byte, or address in multiplexed mode |
| ad_out | output | 8 | AD bus read data |
| ad_oe | output | 1 | AD bus driver enable |
| dhi_in | input | 8 | Upper data byte input |
| dhi_out | output | 8 | Upper data byte read data |
| dhi_oe | output | 1 | Upper byte driver enable |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ale_in | input | 1 | Address strobe (multiplexed mode) |
| ale_out | output | 1 | Pull-up control value (split mode) |
| ale_oe | output | 1 | Pull-up control enable; 0 means high impedance |
| irq_int | input | 1 | Internal interrupt, active high |
| irq_pin | output | 1 | Interrupt pin, programmable polarity |
| dreq_int | input | 2 | Internal DMA requests, active high |
| dreq_pin | output | 2 | DMA request pins, programmable polarity |
| dack_pin | input | 2 | DMA acknowledge pins, programmable polarity |
| reg_addr | output | 7 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_wr | output | 1 | Register write enable, one cycle |
| reg_rd | output | 1 | Register read enable, one cycle |
| reg_rdata | input | 8 | Register file read data |
| fifo_wdata | output | 16 | FIFO write data |
| fifo_wr | output | 2 | FIFO write enable per channel |
| fifo_rd | output | 2 | FIFO read enable per channel |
| fifo_rdata | input | 16 | FIFO read data of the acknowledged channel |

## Verification
The bench uses the default parameters: a 7-bit address, an 8-bit data byte, and the local registers at 0x7C to 0x7E. Ordinary register traffic uses low addresses, so it never collides with a local register. Traffic can also aim directly at the polarity, control and status registers, so that reprogramming an acknowledge to active low, the 16-bit channel bits and the sticky conflict flag are all reachable in a short run. Both address modes are used in one run, including a captured chip select that is high while the live pin is low.

// File: rtl/host_bus_if.sv
module host_bus_if #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter logic [AW-1:0] POL_ADDR  = 'h7C,
  parameter logic [AW-1:0] CTRL_ADDR = 'h7D,
  parameter logic [AW-1:0] STAT_ADDR = 'h7E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_mux,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] dhi_in,
  output logic [DW-1:0] dhi_out,
  output logic          dhi_oe,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          ale_in,
  output logic          ale_out,
  output logic          ale_oe,
  input  logic          irq_int,
  output logic          irq_pin,
  input  logic [1:0]    dreq_int,
  output logic [1:0]    dreq_pin,
  input  logic [1:0]    dack_pin,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_wr,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata,
  output logic [2*DW-1:0] fifo_wdata,
  output logic [1:0]    fifo_wr,
  output logic [1:0]    fifo_rd,
  input  logic [2*DW-1:0] fifo_rdata
);

  localparam int FW = 2 * DW;
  localparam int PW = 5;

  logic [PW-1:0] pol_q;
  logic [DW-1:0] ctrl_q;
  logic          conf_q;
  logic [AW-1:0] lat_addr;
  logic          lat_cs_n;
  logic          wr_d, rd_d;

  logic [1:0]    dack_int, dma_hot;
  logic          dma_on, sel, wr_go, rd_go;
  logic          hit_pol, hit_ctrl, hit_stat, hit_loc;
  logic [DW-1:0] loc_rdata;

  assign dack_int = dack_pin ^ pol_q[4:3];
  assign dma_on   = |dack_int;
  assign dma_hot  = dack_int[0] ? 2'b01 : {dack_int[1], 1'b0};

  assign reg_addr = mode_mux ? lat_addr : addr_in;
  assign sel      = ~(mode_mux ? lat_cs_n : cs_n) & ~dma_on;
  assign wr_go    = ~wr_n & wr_d;
  assign rd_go    = ~rd_n & rd_d;

  assign hit_pol  = reg_addr == POL_ADDR;
  assign hit_ctrl = reg_addr == CTRL_ADDR;
  assign hit_stat = reg_addr == STAT_ADDR;
  assign hit_loc  = hit_pol | hit_ctrl | hit_stat;

  always_comb begin
    loc_rdata = '0;
    if (hit_pol)  loc_rdata[PW-1:0] = pol_q;
    if (hit_ctrl) loc_rdata = ctrl_q;
    if (hit_stat) loc_rdata[0] = conf_q;
  end

  assign reg_wdata = ad_in;
  assign reg_wr    = wr_go & sel & ~hit_loc;
  assign reg_rd    = rd_go & sel & ~hit_loc;

  assign fifo_wdata = {dhi_in, ad_in};
  assign fifo_wr    = {2{wr_go}} & dma_hot;
  assign fifo_rd    = {2{rd_go}} & dma_hot;

  assign ad_oe   = ~rd_n & (sel | dma_on);
  assign ad_out  = dma_on ? fifo_rdata[DW-1:0] : (hit_loc ? loc_rdata : reg_rdata);
  assign dhi_oe  = ~rd_n & |(dma_hot & ctrl_q[1:0]);
  assign dhi_out = fifo_rdata[FW-1:DW];

  assign irq_pin  = irq_int ^ ~pol_q[0];
  assign dreq_pin = dreq_int ^ ~pol_q[2:1];

  assign ale_out = 1'b1;
  assign ale_oe  = ~mode_mux & ctrl_q[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d     <= 1'b1;
      rd_d     <= 1'b1;
      lat_addr <= '0;
      lat_cs_n <= 1'b1;
    end else begin
      wr_d <= wr_n;
      rd_d <= rd_n;
      if (mode_mux && ale_in) begin
        lat_addr <= ad_in[AW-1:0];
        lat_cs_n <= cs_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      ctrl_q <= '0;
      conf_q <= 1'b0;
    end else begin
      if (wr_go && sel && hit_pol)  pol_q  <= ad_in[PW-1:0];
      if (wr_go && sel && hit_ctrl) ctrl_q <= ad_in;
      if (&dack_int)                conf_q <= 1'b1;
      else if (wr_go && sel && hit_stat && ad_in[0]) conf_q <= 1'b0;
    end
  end

  // R1
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr);
  // R2
  ale_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_mux && ale_in) |=> (lat_addr == $past(ad_in[AW-1:0])));
  // R5
  dma_noreg_chk: assert property (@(posedge clk) disable iff (!rst_n) (|fifo_wr) |-> !reg_wr);
  // R10
  dack_pri_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(fifo_wr));
  // R10
  conf_set_chk: assert property (@(posedge clk) disable iff (!rst_n) (&dack_int) |=> conf_q);
  // R9
  dhi_oe_chk: assert property (@(posedge clk) disable iff (!rst_n) dhi_oe |-> ad_oe);
  // R8
  pullup_mode_chk: assert property (@(posedge clk) disable iff (!rst_n) mode_mux |-> !ale_oe);

endmodule

// File: tb/host_bus_if_tb.sv
module host_bus_if_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, mode_mux = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ale_in = 1'b0;
  logic [6:0] addr_in = '0;
  logic [7:0] ad_in = '0, dhi_in = '0, reg_rdata = '0;
  logic irq_int = 1'b0;
  logic [1:0] dreq_int = '0, dack_pin = '0, dack_idle = '0;
  logic [15:0] fifo_rdata = '0;
  logic [7:0] ad_out, dhi_out, reg_wdata;
  logic ad_oe, dhi_oe, ale_out, ale_oe, irq_pin, reg_wr, reg_rd;
  logic [1:0] dreq_pin, fifo_wr, fifo_rd;
  logic [6:0] reg_addr;
  logic [15:0] fifo_wdata;

  host_bus_if u_dut (
    .clk(clk), .rst_n(rst_n), .mode_mux(mode_mux), .addr_in(addr_in),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .dhi_in(dhi_in), .dhi_out(dhi_out), .dhi_oe(dhi_oe),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ale_in(ale_in), .ale_out(ale_out), .ale_oe(ale_oe),
    .irq_int(irq_int), .irq_pin(irq_pin), .dreq_int(dreq_int), .dreq_pin(dreq_pin),
    .dack_pin(dack_pin), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .fifo_wdata(fifo_wdata), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  string cur_req = "R12";

  logic [4:0] m_pol;
  logic [7:0] m_ctrl;
  logic m_conf, m_lcs, m_wrp, m_rdp;
  logic [6:0] m_la;
  logic [1:0] e_dk, e_hot;
  logic e_dma, e_sel, e_wf, e_rf, e_loc, e_wide;
  logic [6:0] e_addr;
  logic [7:0] e_locv;

  task automatic model_reset();
    m_pol = '0; m_ctrl = '0; m_conf = 1'b0; m_lcs = 1'b1; m_la = '0;
    m_wrp = 1'b1; m_rdp = 1'b1;
  endtask

  task automatic derive();
    e_dk   = dack_pin ^ {m_pol[4], m_pol[3]};
    e_dma  = e_dk != 2'b00;
    e_hot  = e_dk[0] ? 2'b01 : (e_dk[1] ? 2'b10 : 2'b00);
    e_addr = mode_mux ? m_la : addr_in;
    e_sel  = !(mode_mux ? m_lcs : cs_n) && !e_dma;
    e_wf   = !wr_n && m_wrp;
    e_rf   = !rd_n && m_rdp;
    e_loc  = (e_addr == 7'h7C) || (e_addr == 7'h7D) || (e_addr == 7'h7E);
    e_locv = (e_addr == 7'h7C) ? {3'b0, m_pol} :
             (e_addr == 7'h7D) ? m_ctrl : {7'b0, m_conf};
    e_wide = (e_hot == 2'b01) ? m_ctrl[0] : (e_hot == 2'b10) ? m_ctrl[1] : 1'b0;
  endtask

  task automatic chk(string what, logic [15:0] a, logic [15:0] e);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, a, e);
    end
  endtask

  task automatic step();
    logic ewr, erd, eoe;
    #2;
    if (!rst_n) model_reset();
    derive();
    ewr = e_wf && e_sel && !e_loc;
    erd = e_rf && e_sel && !e_loc;
    eoe = !rd_n && (e_sel || e_dma);
    chk("reg_wr", {15'b0, reg_wr}, {15'b0, ewr});
    chk("reg_rd", {15'b0, reg_rd}, {15'b0, erd});
    if (ewr || erd) chk("reg_addr", {9'b0, reg_addr}, {9'b0, e_addr});
    if (ewr) chk("reg_wdata", {8'b0, reg_wdata}, {8'b0, ad_in});
    chk("fifo_wr", {14'b0, fifo_wr}, {14'b0, e_wf ? e_hot : 2'b00});
    chk("fifo_rd", {14'b0, fifo_rd}, {14'b0, e_rf ? e_hot : 2'b00});
    if (e_wf && e_dma) chk("fifo_wdata", fifo_wdata, {dhi_in, ad_in});
    chk("ad_oe", {15'b0, ad_oe}, {15'b0, eoe});
    if (eoe) chk("ad_out", {8'b0, ad_out}, {8'b0, e_dma ? fifo_rdata[7:0] : (e_loc ? e_locv : reg_rdata)});
    chk("dhi_oe", {15'b0, dhi_oe}, {15'b0, !rd_n && e_dma && e_wide});
    if (dhi_oe) chk("dhi_out", {8'b0, dhi_out}, {8'b0, fifo_rdata[15:8]});
    chk("irq_pin", {15'b0, irq_pin}, {15'b0, m_pol[0] ? irq_int : !irq_int});
    chk("dreq_pin0", {15'b0, dreq_pin[0]}, {15'b0, m_pol[1] ? dreq_int[0] : !dreq_int[0]});
    chk("dreq_pin1", {15'b0, dreq_pin[1]}, {15'b0, m_pol[2] ? dreq_int[1] : !dreq_int[1]});
    chk("ale_oe", {15'b0, ale_oe}, {15'b0, !mode_mux && m_ctrl[3]});
    if (ale_oe) chk("ale_out", {15'b0, ale_out}, 16'h1);
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      if (e_wf && e_sel) begin
        if (e_addr == 7'h7C) m_pol = ad_in[4:0];
        if (e_addr == 7'h7D) m_ctrl = ad_in;
        if (e_addr == 7'h7E && ad_in[0] && e_dk != 2'b11) m_conf = 1'b0;
      end
      if (e_dk == 2'b11) m_conf = 1'b1;
      if (mode_mux && ale_in) begin m_la = ad_in[6:0]; m_lcs = cs_n; end
      m_wrp = wr_n; m_rdp = rd_n;
    end
    @(negedge clk);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic bus_wr(logic [6:0] a, logic [7:0] d);
    addr_in = a; ad_in = d; cs_n = 1'b0; dack_pin = dack_idle; step();
    wr_n = 1'b0; steps(2);
    wr_n = 1'b1; step();
    cs_n = 1'b1; step();
  endtask

  task automatic bus_rd(logic [6:0] a);
    addr_in = a; cs_n = 1'b0; dack_pin = dack_idle; step();
    rd_n = 1'b0; steps(2);
    rd_n = 1'b1; step();
    cs_n = 1'b1; step();
  endtask

  task automatic dma_xfer(logic [1:0] dk);
    dack_pin = dk; cs_n = 1'b1; step();
    wr_n = 1'b0; steps(2); wr_n = 1'b1; step();
    rd_n = 1'b0; steps(2); rd_n = 1'b1; step();
    dack_pin = dack_idle; step();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    cur_req = "R12"; steps(3);
    rst_n = 1'b1; steps(2);

    cur_req = "R1"; bus_wr(7'h12, 8'h5A); bus_wr(7'h03, 8'hA5);

    cur_req = "R4"; reg_rdata = 8'hC3; bus_rd(7'h21);
    reg_rdata = 8'h3C; bus_rd(7'h05);

    cur_req = "R3"; cs_n = 1'b1; addr_in = 7'h12;
    wr_n = 1'b0; steps(2); wr_n = 1'b1; rd_n = 1'b0; steps(2); rd_n = 1'b1; step();

    cur_req = "R2"; mode_mux = 1'b1;
    ad_in = 8'h25; cs_n = 1'b0; ale_in = 1'b1; step();
    ale_in = 1'b0; ad_in = 8'h99; step();
    wr_n = 1'b0; steps(2); wr_n = 1'b1; step();
    reg_rdata = 8'h77; rd_n = 1'b0; steps(2); rd_n = 1'b1; cs_n = 1'b1; step();
    ad_in = 8'h30; ale_in = 1'b1; cs_n = 1'b1; step();
    ale_in = 1'b0; cs_n = 1'b0; ad_in = 8'h11; step();
    wr_n = 1'b0; steps(2); wr_n = 1'b1; cs_n = 1'b1; step();
    mode_mux = 1'b0; step();

    cur_req = "R8"; bus_wr(7'h7D, 8'h08); steps(1);
    mode_mux = 1'b1; steps(2); mode_mux = 1'b0; step();

    cur_req = "R11"; bus_rd(7'h7D); bus_rd(7'h7C);

    cur_req = "R5"; fifo_rdata = 16'h1234; ad_in = 8'h44; dhi_in = 8'h11;
    dma_xfer(2'b01); ad_in = 8'h55; dhi_in = 8'h22; dma_xfer(2'b10);

    cur_req = "R9"; bus_wr(7'h7D, 8'h09); fifo_rdata = 16'hBEEF;
    dma_xfer(2'b01); dma_xfer(2'b10);

    cur_req = "R10"; fifo_rdata = 16'h0F0F; dma_xfer(2'b11);
    bus_rd(7'h7E); bus_wr(7'h7E, 8'h01); bus_rd(7'h7E);

    cur_req = "R7"; irq_int = 1'b1; dreq_int = 2'b01; steps(2);
    irq_int = 1'b0; dreq_int = 2'b10; steps(2);

    cur_req = "R6"; bus_wr(7'h7C, 8'h1F); dack_idle = 2'b11; dack_pin = 2'b11; step();
    irq_int = 1'b1; dreq_int = 2'b11; steps(2); irq_int = 1'b0; dreq_int = 2'b00; step();
    dma_xfer(2'b10); dma_xfer(2'b01);
    cur_req = "R11"; bus_rd(7'h7C);

    cur_req = "R12"; rst_n = 1'b0; steps(2); rst_n = 1'b1; dack_idle = 2'b00; dack_pin = 2'b00;
    irq_int = 1'b1; steps(2); bus_rd(7'h7C); bus_rd(7'h7D);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule